// File: doc/BRIEF.md
# Selectable Periodic Interrupt Generator

This block raises a periodic event flag at one of six rates picked by a 3-bit select field of a control byte. A prescaler counts base ticks (one strobe per 1/512 s by default), and each rate is the rising edge of one prescaler bit. A select value of zero, or the unused value seven, turns the periodic event off. The flag stays set until software writes a zero to its bit. The interrupt output follows the flag only while a valid rate is selected.

Software reads and writes one control byte. Bit 7 is the event flag. Bits 6:4 are the rate select. Bits 3:0 read as zero. A prescaler clear input restarts the period count, for example after the time is set.

Top module: `pirq_top`

## Requirements
- R1: After synchronous reset, the control byte reads 8'h60: rate code 6, flag clear, and `irq` is low.
- R2: With the default PRE_W of 9, rate codes 1, 2, 3, 4, 5 and 6 give a flag period of 2, 8, 32, 128, 256 and 512 base ticks. These are 256, 64, 16, 4, 2 and 1 Hz at a 512 Hz tick.
- R3: After a prescaler clear, the first flag set for a code of period P happens on base tick P/2. Later sets happen every P ticks after that. The flag is visible in the clock cycle after the tick is sampled.
- R4: A write with bit 7 = 0 clears the flag. A write with bit 7 = 1 leaves the flag unchanged. Writes update bits 6:4 in either case.
- R5: With rate code 0 or 7, the flag is never set and `irq` stays low.
- R6: `irq` is high exactly when the flag is set and the rate code is 1 to 6. A flag left set under code 0 or 7 reads back as 1 but does not drive `irq`.
- R7: Changing the rate code never sets the flag by itself. Only a tick that makes the selected prescaler bit rise can set it.
- R8: `pre_clr` zeroes the prescaler, and no flag set happens in that cycle. Counting then restarts as in R3.
- R9: If a set event and a clearing write happen in the same cycle, the flag ends up set.
- R10: The read byte shows the flag on bit 7, the rate code on bits 6:4, and zeros on bits 3:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle base tick strobe that advances the prescaler |
| pre_clr | input | 1 | Synchronous prescaler restart |
| wr_en | input | 1 | Control byte write strobe |
| wr_data | input | 8 | Write data: bit 7 is the flag (0 clears it), bits 6:4 are the rate code |
| rd_data | output | 8 | Control byte readback |
| irq | output | 1 | Periodic interrupt request |

## Verification
The assertions check several rules on every cycle:
- the reset value;
- the gating of `irq` by the flag and the rate code;
- that the flag never rises without a tick in the previous cycle, and never rises under code 0 or 7;
- that a clearing write with no tick leaves the flag low.

Other behaviour needs a counted stimulus history, so only the directed scenarios can show it. This covers the exact set position and period for each code, the restart after a prescaler clear, and the absence of a set when the code switches to a prescaler bit that is already high.

// File: rtl/pirq_pkg.sv
// Package: rate code encoding and the mapping from code to prescaler bit.
// Assumes the prescaler MSB toggles at 1 Hz and each lower bit doubles that rate.
package pirq_pkg;

    typedef enum logic [2:0] {
        RATE_OFF  = 3'd0,
        RATE_256  = 3'd1,
        RATE_64   = 3'd2,
        RATE_16   = 3'd3,
        RATE_4    = 3'd4,
        RATE_2    = 3'd5,
        RATE_1    = 3'd6,
        RATE_RSV  = 3'd7
    } rate_code_e;

    localparam int NUM_RATES = 6;
    localparam int MIN_PRE_W = 9;

    // Distance of the tap below the prescaler MSB for codes 1..6.
    function automatic int tap_depth(input int code);
        case (code)
            1:       return 8;
            2:       return 6;
            3:       return 4;
            4:       return 2;
            5:       return 1;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/pirq_prescaler.sv
// Prescaler: a binary counter that advances on each base tick.
// It also reports, per bit, whether this tick will make that bit rise.
// The rise is taken from the carry chain, not from the previous bit value,
// so it does not depend on which bit is later selected.
// Assumes tick and clr are synchronous one-cycle strobes; clr wins over tick.
module pirq_prescaler #(
    parameter int PRE_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             clr,
    output logic [PRE_W-1:0] rise
);

    logic [PRE_W-1:0] cnt;
    logic             adv;

    assign adv = tick & ~clr;

    // Counter: restart on clr, advance on tick.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt <= '0;
        else if (tick)     cnt <= cnt + 1'b1;
    end

    // Per-bit rise: bit k goes 0->1 when it is 0 and all lower bits are 1.
    genvar k;
    generate
        for (k = 0; k < PRE_W; k++) begin : g_rise
            if (k == 0) begin : g_lsb
                assign rise[k] = adv & ~cnt[0];
            end else begin : g_up
                assign rise[k] = adv & ~cnt[k] & (&cnt[k-1:0]);
            end
        end
    endgenerate

endmodule

// File: rtl/pirq_rate_sel.sv
// Rate selector: decodes the 3-bit rate code and picks the matching tap rise.
// Assumes PRE_W >= MIN_PRE_W. Codes 0 and 7 select nothing.
module pirq_rate_sel
    import pirq_pkg::*;
#(
    parameter int PRE_W = 9
) (
    input  logic [2:0]       code,
    input  logic [PRE_W-1:0] rise,
    output logic             hit,
    output logic             active
);

    logic [NUM_RATES:1] cand;

    genvar i;
    generate
        for (i = 1; i <= NUM_RATES; i++) begin : g_tap
            localparam int TAP = PRE_W - 1 - tap_depth(i);
            assign cand[i] = rise[TAP];
        end
    endgenerate

    // Decode: a valid code enables exactly one candidate.
    always_comb begin
        hit    = 1'b0;
        active = 1'b0;
        for (int c = 1; c <= NUM_RATES; c++) begin
            if (code == 3'(c)) begin
                hit    = cand[c];
                active = 1'b1;
            end
        end
    end

endmodule

// File: rtl/pirq_top.sv
// Periodic interrupt generator top: control byte, event flag and irq gating.
// Assumes base ticks at 512 Hz for the nominal rates; bits 3:0 of the byte are not stored.
module pirq_top
    import pirq_pkg::*;
#(
    parameter int PRE_W = 9
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       pre_clr,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    output logic       irq
);

    localparam int FLAG_BIT = 7;
    localparam int SEL_LO   = 4;

    logic [PRE_W-1:0] rise;
    logic             hit;
    logic             active;
    logic [2:0]       code;
    logic             flag;

    pirq_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .clr   (pre_clr),
        .rise  (rise)
    );

    pirq_rate_sel #(.PRE_W(PRE_W)) u_sel (
        .code   (code),
        .rise   (rise),
        .hit    (hit),
        .active (active)
    );

    // Rate code register: defaults to 1 Hz, loaded on any write.
    always_ff @(posedge clk) begin
        if (!rst_n)     code <= RATE_1;
        else if (wr_en) code <= wr_data[SEL_LO +: 3];
    end

    // Event flag: a set event wins; a write of 0 to the flag bit clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)                        flag <= 1'b0;
        else if (hit)                      flag <= 1'b1;
        else if (wr_en && !wr_data[FLAG_BIT]) flag <= 1'b0;
    end

    assign rd_data = {flag, code, 4'b0000};
    assign irq     = flag & active;

endmodule

// File: rtl/pirq_checker.sv
// Checker for pirq_top: port-level temporal rules, attached by bind.
module pirq_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic [7:0] rd_data,
    input logic       irq
);

    logic code_ok;
    assign code_ok = (rd_data[6:4] != 3'd0) && (rd_data[6:4] != 3'd7);

    // R1: reset brings the byte to its default.
    a_r1_reset_value: assert property (@(posedge clk)
        !rst_n |=> (rd_data == 8'h60) && !irq);

    // R6: irq only with the flag set and a valid code.
    a_r6_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (rd_data[7] && code_ok));

    // R6: a set flag under a valid code drives irq.
    a_r6_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[7] && code_ok) |-> irq);

    // R7: the flag rises only after a tick.
    a_r7_rise_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_data[7] && !tick) |=> !rd_data[7]);

    // R5: off codes never set the flag.
    a_r5_off_no_set: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_data[7] && !code_ok) |=> !rd_data[7]);

    // R4: a clearing write with no tick leaves the flag low.
    a_r4_clear_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_data[7] && !tick) |=> !rd_data[7]);

endmodule

bind pirq_top pirq_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .irq     (irq)
);

// File: tb/sim_pirq_top.sv
module sim_pirq_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       pre_clr = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       irq;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pirq_top u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .pre_clr(pre_clr),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
    );

    function automatic int period_of(input int code);
        case (code)
            1: return 2;
            2: return 8;
            3: return 32;
            4: return 128;
            5: return 256;
            6: return 512;
            default: return 0;
        endcase
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_byte(input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic restart();
        @(negedge clk); pre_clr = 1'b1;
        @(negedge clk); pre_clr = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 reset byte", rd_data, 8'h60);
        chk("R1 reset irq", irq, 0);
    endtask

    task automatic t_rate(input int code);
        int p = period_of(code);
        write_byte({1'b0, 3'(code), 4'h0});
        restart();
        if (p / 2 > 1) begin
            ticks(p / 2 - 1);
            chk($sformatf("R3 code %0d before first set", code), rd_data[7], 0);
            ticks(1);
        end else ticks(1);
        chk($sformatf("R3 code %0d first set", code), rd_data[7], 1);
        chk($sformatf("R6 code %0d irq", code), irq, 1);
        chk($sformatf("R10 code %0d readback", code), rd_data, {1'b1, 3'(code), 4'h0});
        write_byte({1'b0, 3'(code), 4'h0});
        ticks(p - 1);
        chk($sformatf("R2 code %0d before next", code), rd_data[7], 0);
        ticks(1);
        chk($sformatf("R2 code %0d period", code), rd_data[7], 1);
    endtask

    task automatic t_write_keep();
        write_byte(8'h90);
        restart();
        ticks(1);
        write_byte(8'h90);
        chk("R4 write 1 keeps flag", rd_data[7], 1);
        write_byte(8'h10);
        chk("R4 write 0 clears flag", rd_data[7], 0);
    endtask

    task automatic t_off(input int code);
        write_byte({1'b0, 3'(code), 4'h0});
        restart();
        ticks(600);
        chk($sformatf("R5 code %0d no flag", code), rd_data[7], 0);
        chk($sformatf("R5 code %0d no irq", code), irq, 0);
    endtask

    task automatic t_gate();
        write_byte(8'h10);
        restart();
        ticks(1);
        write_byte(8'h80);
        chk("R6 flag kept under code 0", rd_data[7], 1);
        chk("R6 irq gated under code 0", irq, 0);
        write_byte(8'hF0);
        chk("R6 irq gated under code 7", irq, 0);
        write_byte(8'h70);
    endtask

    task automatic t_switch();
        write_byte(8'h60);
        restart();
        ticks(128);
        write_byte(8'h50);
        chk("R7 no set on code change", rd_data[7], 0);
        ticks(1);
        chk("R7 no set after change", rd_data[7], 0);
    endtask

    task automatic t_preclr();
        write_byte(8'h30);
        restart();
        ticks(15);
        restart();
        ticks(15);
        chk("R8 restart delays set", rd_data[7], 0);
        ticks(1);
        chk("R8 set after restart", rd_data[7], 1);
    endtask

    task automatic t_collide();
        write_byte(8'h10);
        restart();
        @(negedge clk); tick = 1'b1; wr_en = 1'b1; wr_data = 8'h10;
        @(negedge clk); tick = 1'b0; wr_en = 1'b0;
        chk("R9 set wins over clear", rd_data[7], 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        for (int c = 1; c <= 6; c++) t_rate(c);
        t_write_keep();
        t_off(0);
        t_off(7);
        t_gate();
        t_switch();
        t_preclr();
        t_collide();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                n_checks++;
                n_errors++;
                $display("FAIL watchdog: actual=timeout expected=done");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule